// File: doc/BRIEF.md
# SPI Addressed Peripheral Selector

This block is the SPI slave front end of a test-harness logic device. Several such devices sit on daughterboards that share one serial bus. The bus has a serial clock, a master-out line and a master-in line. It also has two active-low chip-select lines: one for devices that drive the test vector and one for devices that receive it.

Each device is built for one role, chosen by a parameter. It watches only the chip select of its own role. Once that line falls, the device shifts in a 15-bit address, most significant bit first. The address has three fields, from the top down:

- a 3-bit board number, taken from the low three inputs of a 4-bit DIP switch;
- an 8-bit internal code that is the same constant in every device;
- a 4-bit role code.

When all three fields match, the device raises its selected flag and enables its MISO pad driver. It then returns a fixed status byte over the next eight clocks. A device that is not addressed leaves MISO undriven.

All bus inputs are brought into the system clock through two-flop synchronisers. The edges of the serial clock are detected in the system clock domain.

Top module: `spi_addr_select`

## Requirements
- R1: The address is 15 bits, sent most significant bit first, and sampled on rising serial-clock edges (SPI mode 0). Bits 14..12 hold the board number, bits 11..4 the internal code and bits 3..0 the role code. Selection is decided only when the 15th bit has arrived.
- R2: The board number compared is `dip_sw_i[2:0]`. `dip_sw_i[3]` has no effect on selection.
- R3: A driver-role device (parameter `DRIVER_ROLE` = 1) matches role code 4'hF. A receiver-role device (`DRIVER_ROLE` = 0) matches role code 4'h0.
- R4: The internal code is the parameter `INT_CODE`, default 8'hEC. An address that differs from it in that field does not select the device.
- R5: A driver-role device responds only to `cs_drv_n_i`, and a receiver-role device only to `cs_rcv_n_i`. Traffic under the other line never selects it.
- R6: While the own chip select is high (inactive), the bit counter is held at zero and `selected_o` is low. A partial address followed by a release of chip select does not disturb the next full address.
- R7: `miso_oe_o` is high only while `selected_o` is high. Otherwise the pad stays undriven.
- R8: Once selected, the device returns the status byte `STATUS` (default 8'hA5), MSB first, on the eight serial clocks that follow the address. `miso_o` changes only after falling serial-clock edges. The first bit is valid before the 16th rising edge.
- R9: After reset, `selected_o` and `miso_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the bus master |
| mosi_i | input | 1 | Serial data from the master |
| cs_drv_n_i | input | 1 | Active-low chip select for driver-role devices |
| cs_rcv_n_i | input | 1 | Active-low chip select for receiver-role devices |
| dip_sw_i | input | 4 | Board DIP switch; bit 3 unused |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| selected_o | output | 1 | High while this device is addressed |

## Verification
On every cycle, the assertions check four things:

- selection can only begin on the edge that completes the 15th address bit, and only while the device's own chip select is active;
- an inactive chip select clears the counter and the flag on the next cycle;
- the status register is loaded when selection begins;
- the status register changes only on falling serial-clock edges.

Some behaviours only the bench scenarios can show. These are the field-by-field address decoding, including the ignored DIP bit and the role codes. They also include the fact that one role's chip select leaves the other role's device idle, the actual bit pattern of the returned byte, and recovery after an aborted address.

// File: rtl/spi_addr_select_pkg.sv
// Package: shared widths and constants for the addressed SPI selector.
// Assumes the 3/8/4 address split; every module sizes itself from these.
package spi_addr_select_pkg;
    localparam int BOARD_W = 3;
    localparam int CODE_W  = 8;
    localparam int ROLE_W  = 4;
    localparam int ADDR_W  = BOARD_W + CODE_W + ROLE_W;
    localparam int BYTE_W  = 8;
    localparam logic [ROLE_W-1:0] ROLE_DRIVER   = '1;
    localparam logic [ROLE_W-1:0] ROLE_RECEIVER = '0;
endpackage

// File: rtl/sas_sync.sv
// Module: multi-bit two-flop synchroniser.
// Assumes each bit is an independent slow signal; no bus coherence is claimed.
module sas_sync #(
    parameter int WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1;

    // Two-stage capture of asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/sas_addr_rx.sv
// Module: address shifter and comparator.
// Shifts MOSI in on each rising-edge strobe while chip select is active and
// compares the completed word against the device address on the last bit.
// Assumes strobes are one system-clock wide.
module sas_addr_rx
    import spi_addr_select_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active_i,
    input  logic              sck_rise_i,
    input  logic              mosi_i,
    input  logic [ADDR_W-1:0] my_addr_i,
    output logic              sel_o
);
    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W - 1);

    logic [ADDR_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              done;
    logic [ADDR_W-1:0] next_word;

    assign next_word = {shreg[ADDR_W-2:0], mosi_i};

    // Shift address bits and decide selection on the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active_i) begin
            shreg <= '0;
            cnt   <= '0;
            done  <= 1'b0;
            sel_o <= 1'b0;
        end else if (sck_rise_i && !done) begin
            shreg <= next_word;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) begin
                done  <= 1'b1;
                sel_o <= (next_word == my_addr_i);
            end
        end
    end

    // R1: selection only begins on the strobe that completes the address
    p_sel_after_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> ($past(cnt) == LAST && $past(sck_rise_i)));

    // R6: inactive chip select clears counter and flag
    p_cs_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active_i |=> (cnt == '0 && !sel_o));
endmodule

// File: rtl/sas_status_tx.sv
// Module: status byte transmitter.
// Loads the status byte when selection begins, presents its MSB at once and
// shifts left on falling-edge strobes, skipping the falling edge of the last
// address bit. Assumes sel_i rises between that bit's rising and falling edge.
module sas_status_tx
    import spi_addr_select_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STATUS = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sck_fall_i,
    output logic miso_o
);
    logic [BYTE_W-1:0] tx_reg;
    logic              sel_q;
    logic              skip;
    logic              load;

    assign load   = sel_i && !sel_q;
    assign miso_o = tx_reg[BYTE_W-1];

    // Load on selection, then shift out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_reg <= '0;
            sel_q  <= 1'b0;
            skip   <= 1'b0;
        end else begin
            sel_q <= sel_i;
            if (load) begin
                tx_reg <= STATUS;
                skip   <= 1'b1;
            end else if (sck_fall_i && sel_i) begin
                if (skip) skip <= 1'b0;
                else      tx_reg <= {tx_reg[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // R8: status byte loaded when selection begins
    p_load_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_i) |=> (tx_reg == STATUS));

    // R8: output register moves only on falling edges or a load
    p_shift_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall_i && !load) |=> $stable(tx_reg));
endmodule

// File: rtl/spi_addr_select.sv
// Module: addressed SPI slave selector (top).
// Synchronises the bus, detects serial-clock edges, picks the chip select of
// its role, and assembles its address from DIP switches and constants.
// Assumes the system clock is at least eight times the serial clock.
module spi_addr_select
    import spi_addr_select_pkg::*;
#(
    parameter bit                DRIVER_ROLE = 1'b1,
    parameter logic [CODE_W-1:0] INT_CODE    = 8'hEC,
    parameter logic [BYTE_W-1:0] STATUS      = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic       cs_drv_n_i,
    input  logic       cs_rcv_n_i,
    input  logic [3:0] dip_sw_i,
    output logic       miso_o,
    output logic       miso_oe_o,
    output logic       selected_o
);
    logic       own_cs_n;
    logic [2:0] bus_s;
    logic       sck_q;
    logic       sck_rise, sck_fall, cs_active;
    logic [ROLE_W-1:0] role_code;
    logic [ADDR_W-1:0] my_addr;

    // Role variant: choose chip select and role code.
    generate
        if (DRIVER_ROLE) begin : g_drv
            assign own_cs_n  = cs_drv_n_i;
            assign role_code = ROLE_DRIVER;
        end else begin : g_rcv
            assign own_cs_n  = cs_rcv_n_i;
            assign role_code = ROLE_RECEIVER;
        end
    endgenerate

    assign my_addr = {dip_sw_i[BOARD_W-1:0], INT_CODE, role_code};

    sas_sync #(.WIDTH(3), .RST_VAL(3'b100)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({own_cs_n, mosi_i, sck_i}),
        .sync_o (bus_s)
    );

    // Remember previous serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= bus_s[0];
    end

    assign sck_rise  = bus_s[0] && !sck_q;
    assign sck_fall  = !bus_s[0] && sck_q;
    assign cs_active = !bus_s[2];

    sas_addr_rx i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active_i(cs_active),
        .sck_rise_i (sck_rise),
        .mosi_i     (bus_s[1]),
        .my_addr_i  (my_addr),
        .sel_o      (selected_o)
    );

    sas_status_tx #(.STATUS(STATUS)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (selected_o),
        .sck_fall_i(sck_fall),
        .miso_o    (miso_o)
    );

    assign miso_oe_o = selected_o;

    // R5: selection begins only while own chip select is active
    p_own_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected_o) |-> $past(cs_active));
endmodule

// File: tb/test_spi_addr_select.sv
module test_spi_addr_select;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, cs_drv_n = 1'b1, cs_rcv_n = 1'b1;
    logic [3:0] dip = 4'h3;
    logic d_miso, d_oe, d_sel, r_miso, r_oe, r_sel;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    spi_addr_select #(.DRIVER_ROLE(1'b1)) i_spi_addr_select (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi),
        .cs_drv_n_i(cs_drv_n), .cs_rcv_n_i(cs_rcv_n), .dip_sw_i(dip),
        .miso_o(d_miso), .miso_oe_o(d_oe), .selected_o(d_sel));

    spi_addr_select #(.DRIVER_ROLE(1'b0)) i_spi_addr_select_rcv (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi),
        .cs_drv_n_i(cs_drv_n), .cs_rcv_n_i(cs_rcv_n), .dip_sw_i(dip),
        .miso_o(r_miso), .miso_oe_o(r_oe), .selected_o(r_sel));

    // vector: {dip[3:0], use_rcv_cs, addr[14:0], exp_drv_sel, exp_rcv_sel}
    localparam int NV = 10;
    localparam logic [21:0] VEC [NV] = '{
        {4'h3, 1'b0, 3'd3, 8'hEC, 4'hF, 1'b1, 1'b0},  // R1 R3 driver on board 3
        {4'h3, 1'b1, 3'd3, 8'hEC, 4'h0, 1'b0, 1'b1},  // R3 receiver on board 3
        {4'hB, 1'b0, 3'd3, 8'hEC, 4'hF, 1'b1, 1'b0},  // R2 top DIP bit ignored
        {4'h3, 1'b1, 3'd3, 8'hEC, 4'hF, 1'b0, 1'b0},  // R5 driver addr on rcv cs
        {4'h3, 1'b0, 3'd3, 8'hEC, 4'h0, 1'b0, 1'b0},  // R5 rcv addr on drv cs
        {4'h3, 1'b0, 3'd2, 8'hEC, 4'hF, 1'b0, 1'b0},  // R2 board mismatch
        {4'h3, 1'b0, 3'd3, 8'hED, 4'hF, 1'b0, 1'b0},  // R4 internal code mismatch
        {4'h5, 1'b0, 3'd5, 8'hEC, 4'hF, 1'b1, 1'b0},  // R1 board 5 driver
        {4'h0, 1'b1, 3'd0, 8'hEC, 4'h0, 1'b0, 1'b1},  // R3 board 0 receiver
        {4'h7, 1'b0, 3'd3, 8'hEC, 4'hF, 1'b0, 1'b0}   // R2 board 7 vs addr 3
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        mosi = b;
        #100 sck = 1'b1;
        #100 sck = 1'b0;
    endtask

    // Send nbits of addr (MSB first) with the chosen chip select, no release.
    task automatic send_addr(input logic use_rcv, input logic [14:0] a, input int nbits);
        if (use_rcv) cs_rcv_n = 1'b0; else cs_drv_n = 1'b0;
        #100;
        for (int i = 14; i > 14 - nbits; i--) bit_out(a[i]);
        #100;
    endtask

    // Clock eight status bits, sampling just before each rising edge.
    task automatic read_byte(output logic [7:0] b);
        mosi = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            #100 b[i] = d_oe ? d_miso : (r_oe ? r_miso : 1'b1);
            sck = 1'b1;
            #100 sck = 1'b0;
        end
    endtask

    task automatic release_cs;
        cs_drv_n = 1'b1;
        cs_rcv_n = 1'b1;
        #200;
    endtask

    initial begin : watchdog
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        #2;
        chk("R9 drv sel in reset", {7'd0, d_sel}, 8'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        chk("R9 drv sel after reset", {7'd0, d_sel}, 8'd0);
        chk("R9 drv oe after reset", {7'd0, d_oe}, 8'd0);
        chk("R9 rcv oe after reset", {7'd0, r_oe}, 8'd0);

        for (int v = 0; v < NV; v++) begin
            dip = VEC[v][21:18];
            #100;
            send_addr(VEC[v][17], VEC[v][16:2], 15);
            chk($sformatf("R1/R5 vec%0d drv sel", v), {7'd0, d_sel}, {7'd0, VEC[v][1]});
            chk($sformatf("R1/R5 vec%0d rcv sel", v), {7'd0, r_sel}, {7'd0, VEC[v][0]});
            chk($sformatf("R7 vec%0d drv oe", v), {7'd0, d_oe}, {7'd0, VEC[v][1]});
            chk($sformatf("R7 vec%0d rcv oe", v), {7'd0, r_oe}, {7'd0, VEC[v][0]});
            if (VEC[v][1] || VEC[v][0]) begin
                read_byte(rb);
                chk($sformatf("R8 vec%0d status", v), rb, 8'hA5);
            end
            release_cs();
            chk($sformatf("R6 vec%0d sel clear", v), {6'd0, d_sel, r_sel}, 8'd0);
        end

        // R6: partial address then release, then a full address
        dip = 4'h3;
        send_addr(1'b0, {3'd3, 8'hEC, 4'hF}, 7);
        chk("R6 partial no select", {7'd0, d_sel}, 8'd0);
        release_cs();
        send_addr(1'b0, {3'd3, 8'hEC, 4'hF}, 15);
        chk("R6 full after abort", {7'd0, d_sel}, 8'd1);
        // R6/R7: release during status byte
        bit_out(1'b0);
        release_cs();
        chk("R7 oe off after release", {7'd0, d_oe}, 8'd0);
        chk("R6 sel off after release", {7'd0, d_sel}, 8'd0);

        // R1: 14 bits only never selects
        send_addr(1'b0, {3'd3, 8'hEC, 4'hF}, 14);
        chk("R1 fourteen bits no select", {7'd0, d_sel}, 8'd0);
        release_cs();

        // R8: second byte after status returns zeros
        send_addr(1'b1, {3'd3, 8'hEC, 4'h0}, 15);
        read_byte(rb);
        chk("R8 receiver status", rb, 8'hA5);
        read_byte(rb);
        chk("R8 after status zero", rb, 8'h00);
        release_cs();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule